// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a periodic heartbeat timer. A 24-bit counter counts down toward zero. Each step comes either from every core clock cycle or from one cycle in eight. When the counter steps from one to zero, the block raises a sticky flag, optionally drives an interrupt line, and reloads on its next step. Programming a reload value of N-1 therefore gives a period of exactly N steps. For example, 71999 gives a 1 kHz tick from a 72 MHz core clock. The count path never passes through any bus divider.

Alongside the down-counter, a 32-bit tally counts completed periods. It wraps modulo 2^32, so software measures elapsed time by unsigned subtraction of two tally readings. Software configures and observes the block through a small word-wide register port. Reads return data one cycle after the request.

Top module: `tick_timer`

## Requirements
- R1: The reload register at address 1 keeps only the low 24 bits of a write. Reading it returns those bits with the upper 8 bits zero.
- R2: The counter steps only on count edges. A step at zero loads the reload value. A step from a non-zero value subtracts one. A reload of N-1 gives one flag event every N count edges. The current value is read at address 2.
- R3: With the control bit 2 set, every enabled cycle is a count edge. With bit 2 clear, a count edge occurs on the 8th enabled cycle and every 8 cycles after it. The count starts when the enable bit takes effect.
- R4: A step from 1 to 0 sets the flag. The irq_o output is high in the cycle after any update that leaves the flag set and the interrupt-enable bit (bit 1) set.
- R5: A read of the control register (address 0) returns the flag at bit 16 and clears it. If a 1-to-0 step happens in the same cycle, the flag stays set.
- R6: Any write to address 2 clears the counter and the flag. This takes priority over a count edge in the same cycle.
- R7: With a reload value of zero, the counter stays at zero and never sets the flag or advances the tally.
- R8: While the enable bit (bit 0) is clear, the counter holds its value.
- R9: The tally at address 3 increases by one on each 1-to-0 step, modulo 2^32.
- R10: After reset, every register reads zero and irq_o is low. Read data appears on rdata_o in the cycle after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address (0 control, 1 reload, 2 current, 3 tally) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt: flag and interrupt enable both set |

## Verification
The case that needs care is a read of the control register in the same cycle as the counter's step from one to zero. The read wants to clear the flag, and the step wants to set it. The bench provokes this by setting the reload value to 1 in core-clock mode, where a wrap occurs every other cycle, and then reading the control register on every cycle. It then checks that the flag read back afterwards and irq_o both show the flag still set. A second collision, a write to the current value on a count edge, is provoked the same way. It is judged by the cleared counter value and the tally, which must not advance.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_IE_BIT   = 1;
  localparam int unsigned CTL_SRC_BIT  = 2;
  localparam int unsigned CTL_FLAG_BIT = 16;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_VALUE  = 2'd2,
    REG_TALLY  = 2'd3
  } tick_reg_e;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic core_sel_i,
  output logic step_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] phase_q;
      logic          last;
      assign last = (phase_q == PW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || !en_i) phase_q <= '0;
        else if (last)    phase_q <= '0;
        else              phase_q <= phase_q + 1'b1;
      end
      assign step_o = en_i && (core_sel_i || last);

      a_r3_div_spacing: assert property (@(posedge clk) disable iff (rst)
        (step_o && !core_sel_i) |=> (!step_o || core_sel_i));
    end else begin : g_nodiv
      assign step_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic         clear_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] value_o,
  output logic         wrap_o
);
  logic [W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)         value_q <= '0;
    else if (step_i) begin
      if (value_q == '0)        value_q <= reload_i;
      else                      value_q <= value_q - 1'b1;
    end
  end

  assign value_o = value_q;
  assign wrap_o  = step_i && !clear_i && (value_q == W'(1));

  a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i && value_q > W'(1)) |=> (value_q == $past(value_q) - 1'b1));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (value_q == '0));
  a_r7_zero_reload: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i && value_q == '0 && reload_i == '0) |=> (value_q == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !clear_i) |=> $stable(value_q));
endmodule

// File: rtl/tick_tally.sv
module tick_tally #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (inc_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  a_r9_increment: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> (count_q == $past(count_q) + 1'b1));
  a_r9_steady: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(count_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned TALLY_W = 32,
  parameter int unsigned DIV     = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             en_q, ie_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] value;
  logic [TALLY_W-1:0] tally;
  logic [DATA_W-1:0] rdata_q;
  logic             step, wrap;
  logic             wr_ctrl, wr_reload, wr_value, rd_ctrl;
  logic             flag_d, ie_d;

  assign wr_ctrl   = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_reload = wr_en_i && (addr_i == ADDR_W'(REG_RELOAD));
  assign wr_value  = wr_en_i && (addr_i == ADDR_W'(REG_VALUE));
  assign rd_ctrl   = rd_en_i && (addr_i == ADDR_W'(REG_CTRL));

  tick_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .en_i(en_q), .core_sel_i(src_q), .step_o(step)
  );

  tick_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .clear_i(wr_value),
    .reload_i(reload_q), .value_o(value), .wrap_o(wrap)
  );

  tick_tally #(.W(TALLY_W)) u_tally (
    .clk(clk), .rst(rst), .inc_i(wrap), .count_o(tally)
  );

  always_comb begin
    flag_d = wrap || (flag_q && !rd_ctrl && !wr_value);
    ie_d   = wr_ctrl ? wdata_i[CTL_IE_BIT] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      src_q    <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[CTL_EN_BIT];
        src_q <= wdata_i[CTL_SRC_BIT];
      end
      ie_q   <= ie_d;
      if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
      flag_q <= flag_d;
      irq_q  <= flag_d && ie_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en_i) begin
      rdata_q <= '0;
      case (addr_i)
        ADDR_W'(REG_CTRL): begin
          rdata_q[CTL_EN_BIT]   <= en_q;
          rdata_q[CTL_IE_BIT]   <= ie_q;
          rdata_q[CTL_SRC_BIT]  <= src_q;
          rdata_q[CTL_FLAG_BIT] <= flag_q;
        end
        ADDR_W'(REG_RELOAD): rdata_q[CNT_W-1:0] <= reload_q;
        ADDR_W'(REG_VALUE):  rdata_q[CNT_W-1:0] <= value;
        default:             rdata_q[TALLY_W-1:0] <= tally;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !wrap) |=> !flag_q);
  a_r6_write_clears_flag: assert property (@(posedge clk) disable iff (rst)
    wr_value |=> !flag_q);
  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_q);
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R10";

  always #2 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit          m_en, m_ie, m_core, m_flag, m_irq, m_rvalid;
  int unsigned m_cur, m_reload, m_pc;
  logic [31:0] m_ticks, m_rdata;

  always @(posedge clk) begin
    bit ce, wrap, wcur;
    if (rst) begin
      m_en = 0; m_ie = 0; m_core = 0; m_flag = 0; m_irq = 0; m_rvalid = 0;
      m_cur = 0; m_reload = 0; m_pc = 0; m_ticks = 0; m_rdata = 0;
    end else begin
      m_rvalid = rd_en;
      if (rd_en) begin
        case (addr)
          2'd0: m_rdata = {15'd0, m_flag, 13'd0, m_core, m_ie, m_en};
          2'd1: m_rdata = m_reload;
          2'd2: m_rdata = m_cur;
          default: m_rdata = m_ticks;
        endcase
      end
      ce = m_en && (m_core || m_pc == 7);
      if (!m_en) m_pc = 0; else m_pc = (m_pc + 1) % 8;
      wcur = wr_en && addr == 2'd2;
      wrap = 0;
      if (wcur) m_cur = 0;
      else if (ce) begin
        if (m_cur == 0) m_cur = m_reload;
        else begin
          if (m_cur == 1) wrap = 1;
          m_cur = m_cur - 1;
        end
      end
      if (wrap) m_flag = 1;
      else if (wcur || (rd_en && addr == 2'd0)) m_flag = 0;
      if (wrap) m_ticks = m_ticks + 1;
      if (wr_en && addr == 2'd0) begin
        m_en = wdata[0]; m_ie = wdata[1]; m_core = wdata[2];
      end
      if (wr_en && addr == 2'd1) m_reload = wdata & 32'h00FF_FFFF;
      m_irq = m_flag && m_ie;
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4", {31'd0, irq}, {31'd0, m_irq});
      if (m_rvalid) check(tag, rdata, m_rdata);
    end
  end

  task automatic bus(input bit w, input bit r, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) bus(0, 0, 2'd0, 32'd0);
  endtask

  task automatic read_all();
    for (int i = 0; i < 4; i++) bus(0, 1, 2'(i), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R10"; read_all(); idle(1);
    check("R10", {31'd0, irq}, 32'd0);

    tag = "R1"; bus(1, 0, 2'd1, 32'hFFFF_FFFF); bus(0, 1, 2'd1, 0); idle(1);
    check("R1", rdata, 32'h00FF_FFFF);

    // core-rate run, period 5
    tag = "R2"; bus(1, 0, 2'd1, 32'd4); bus(1, 0, 2'd0, 32'h7);
    for (int i = 0; i < 30; i++) bus(0, 1, 2'd2, 0);
    tag = "R9"; bus(0, 1, 2'd3, 0); idle(1);
    check("R9", rdata, 32'd6);

    // read-clear colliding with wrap
    tag = "R5"; bus(1, 0, 2'd1, 32'd1); bus(1, 0, 2'd2, 0);
    for (int i = 0; i < 20; i++) bus(0, 1, 2'd0, 0);

    // write to value on count edges
    tag = "R6";
    for (int i = 0; i < 6; i++) begin bus(1, 0, 2'd2, 0); bus(0, 1, 2'd2, 0); end
    bus(0, 1, 2'd0, 0); idle(1);
    check("R6", rdata & 32'h0001_0000, 32'd0);

    // divide-by-eight mode
    tag = "R3"; bus(1, 0, 2'd1, 32'd2); bus(1, 0, 2'd2, 0); bus(1, 0, 2'd0, 32'h3);
    for (int i = 0; i < 80; i++) bus(0, 1, 2'(i % 4), 0);

    // disabled hold
    tag = "R8"; bus(1, 0, 2'd0, 32'h2);
    for (int i = 0; i < 20; i++) bus(0, 1, 2'd2, 0);

    // zero reload
    tag = "R7"; bus(1, 0, 2'd1, 32'd0); bus(1, 0, 2'd2, 0); bus(1, 0, 2'd0, 32'h7);
    for (int i = 0; i < 30; i++) bus(0, 1, 2'(i % 4), 0);

    // 1 kHz from 72 MHz: one period of 72000 edges
    tag = "R2"; bus(1, 0, 2'd0, 32'h0); bus(1, 0, 2'd1, 32'd71999);
    bus(1, 0, 2'd2, 0); bus(0, 1, 2'd3, 0); idle(1);
    begin
      logic [31:0] t0;
      t0 = rdata;
      bus(1, 0, 2'd0, 32'h5);
      idle(72001);
      bus(0, 1, 2'd3, 0); idle(1);
      check("R9", rdata - t0, 32'd1);
    end
    idle(4);
    finish_run();
  end
endmodule